// File: doc/BRIEF.md
# Flashlamp Pulse Sequencer

This block drives the three logic-level control lines of a pulsed laser transmitter on a test bench. An operator holds a push-button. While it stays held, the block runs the same firing cycle over and over. Each cycle turns on the high-voltage charger, then strobes the flashlamp trigger, then strobes the discharge switch, then rests before it looks at the button again.

The raw button passes through a synchroniser and a debounce filter before the control logic sees it. All step durations are given in microseconds. A single microsecond prescaler, derived from a clock-frequency parameter, converts them to clock cycles. A bench can therefore shorten every interval by changing parameters only. A cycle that has started always runs to its end. The block also provides a busy flag and a one-cycle completion strobe, so that completed cycles can be counted from outside.

Top module: `flp_sequencer`

## Requirements
- R1: The button input is active low (0 = pressed). While the filtered button reads high, the block stays idle: busy is 0 and no output is active.
- R2: The charger enable is active low. It is 1 (charger off) during reset and whenever the block is not in the charge step.
- R3: The trigger and fire outputs are active high. They are 0 during reset and while idle, and busy is 0 in both cases.
- R4: The charge step holds the charger enable low for exactly CHARGE_US x PRESCALE cycles. In the clock cycle where the charger enable returns high, the trigger output goes high.
- R5: After the trigger ends, all outputs stay inactive for exactly GAP_US x PRESCALE cycles, and then the fire output goes high.
- R6: After the fire pulse, the block rests for exactly WAIT_US x PRESCALE cycles. If the filtered button is still pressed in the last rest cycle, the charger enable goes low in the next cycle. Otherwise the block returns to idle.
- R7: The trigger pulse and the fire pulse each last exactly PULSE_US x PRESCALE cycles.
- R8: At most one of the following is active in any cycle: charger enable (low), trigger (high), fire (high).
- R9: A change of the button level reaches the control logic only after it has stayed stable for DEBOUNCE_US x PRESCALE cycles behind a two-stage synchroniser. Shorter glitches start no cycle.
- R10: Releasing the button in the middle of a cycle does not abort it. Trigger, gap, fire and rest all still complete.
- R11: cycleDone is high for exactly one cycle, the last cycle of each rest step. busy is high from the first charge cycle until the end of the rest step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| buttonN | input | 1 | Raw operator button, active low, asynchronous |
| chargerEnN | output | 1 | High-voltage charger enable, active low |
| triggerOut | output | 1 | Flashlamp trigger pulse, active high |
| fireOut | output | 1 | Discharge switch pulse, active high |
| busy | output | 1 | A firing cycle is in progress |
| cycleDone | output | 1 | One-cycle strobe in the last cycle of each rest step |

## Verification
The bench builds the block with CLK_HZ = 4 MHz, which gives a prescale of four clocks per microsecond. It sets charge to 50 us, pulse to 9 us, gap to 16 us, rest to 70 us and debounce to 10 us. These values shrink a cycle from almost half a second to about six hundred clocks. Three back-to-back cycles, a release in mid-cycle and a sub-debounce glitch therefore fit in a short run. Because the prescale is above one, every exact width check also confirms that the prescaler wraps correctly across microsecond boundaries.

// File: rtl/flp_pkg.sv
package flp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHARGE,
    ST_TRIG,
    ST_GAP,
    ST_FIRE,
    ST_REST
  } seqState_t;

  typedef enum logic [1:0] {
    IV_CHARGE,
    IV_PULSE,
    IV_GAP,
    IV_WAIT
  } interval_t;

  typedef struct packed {
    logic      load;
    interval_t sel;
  } timerCtrl_t;

endpackage

// File: rtl/flp_button_filter.sv
module flp_button_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRawN,
  output logic pressed
);
  localparam int CNT_W = (STABLE_CYC > 1) ? $clog2(STABLE_CYC + 1) : 1;

  logic syncOut;
  logic stableLvl;
  logic [CNT_W-1:0] cnt;

  generate
    if (SYNC_STAGES <= 1) begin : g_oneStage
      logic syncReg;
      always_ff @(posedge clk) begin
        if (rst) syncReg <= 1'b1;
        else     syncReg <= btnRawN;
      end
      assign syncOut = syncReg;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] syncReg;
      always_ff @(posedge clk) begin
        if (rst) syncReg <= '1;
        else     syncReg <= {syncReg[SYNC_STAGES-2:0], btnRawN};
      end
      assign syncOut = syncReg[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stableLvl <= 1'b1;
      cnt       <= '0;
    end else if (syncOut == stableLvl) begin
      cnt <= '0;
    end else if (cnt == CNT_W'(STABLE_CYC - 1)) begin
      stableLvl <= syncOut;
      cnt       <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign pressed = ~stableLvl;
endmodule

// File: rtl/flp_interval_timer.sv
module flp_interval_timer
  import flp_pkg::*;
#(
  parameter int PRESCALE  = 12,
  parameter int CHARGE_US = 200_000,
  parameter int PULSE_US  = 9_000,
  parameter int GAP_US    = 160,
  parameter int WAIT_US   = 280_000
) (
  input  logic       clk,
  input  logic       rst,
  input  timerCtrl_t tctl,
  output logic       expired
);
  localparam int MAX_A  = (CHARGE_US > PULSE_US) ? CHARGE_US : PULSE_US;
  localparam int MAX_B  = (GAP_US > WAIT_US) ? GAP_US : WAIT_US;
  localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int US_W   = $clog2(MAX_US + 1);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0] preCnt;
  logic [US_W-1:0]  usLeft;
  logic [US_W-1:0]  dur;
  logic             usTick;

  always_comb begin
    unique case (tctl.sel)
      IV_CHARGE: dur = US_W'(CHARGE_US);
      IV_PULSE:  dur = US_W'(PULSE_US);
      IV_GAP:    dur = US_W'(GAP_US);
      default:   dur = US_W'(WAIT_US);
    endcase
  end

  assign usTick  = (preCnt == '0);
  assign expired = usTick && (usLeft == US_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      usLeft <= '0;
    end else if (tctl.load) begin
      preCnt <= PRE_W'(PRESCALE - 1);
      usLeft <= dur;
    end else if (usTick) begin
      preCnt <= PRE_W'(PRESCALE - 1);
      if (usLeft != '0) usLeft <= usLeft - US_W'(1);
    end else begin
      preCnt <= preCnt - PRE_W'(1);
    end
  end
endmodule

// File: rtl/flp_sequence_ctrl.sv
module flp_sequence_ctrl
  import flp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pressed,
  input  logic       expired,
  output timerCtrl_t tctl,
  output logic       chargerEnN,
  output logic       triggerOut,
  output logic       fireOut,
  output logic       busy,
  output logic       cycleDone
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    tctl.load = 1'b0;
    tctl.sel  = IV_CHARGE;
    unique case (state)
      ST_IDLE: if (pressed) begin
        nextState = ST_CHARGE;
        tctl.load = 1'b1;
        tctl.sel  = IV_CHARGE;
      end
      ST_CHARGE: if (expired) begin
        nextState = ST_TRIG;
        tctl.load = 1'b1;
        tctl.sel  = IV_PULSE;
      end
      ST_TRIG: if (expired) begin
        nextState = ST_GAP;
        tctl.load = 1'b1;
        tctl.sel  = IV_GAP;
      end
      ST_GAP: if (expired) begin
        nextState = ST_FIRE;
        tctl.load = 1'b1;
        tctl.sel  = IV_PULSE;
      end
      ST_FIRE: if (expired) begin
        nextState = ST_REST;
        tctl.load = 1'b1;
        tctl.sel  = IV_WAIT;
      end
      default: if (expired) begin
        if (pressed) begin
          nextState = ST_CHARGE;
          tctl.load = 1'b1;
          tctl.sel  = IV_CHARGE;
        end else begin
          nextState = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign chargerEnN = (state != ST_CHARGE);
  assign triggerOut = (state == ST_TRIG);
  assign fireOut    = (state == ST_FIRE);
  assign busy       = (state != ST_IDLE);
  assign cycleDone  = (state == ST_REST) && expired;
endmodule

// File: rtl/flp_sequencer.sv
module flp_sequencer
  import flp_pkg::*;
#(
  parameter int CLK_HZ      = 12_000_000,
  parameter int CHARGE_US   = 200_000,
  parameter int PULSE_US    = 9_000,
  parameter int GAP_US      = 160,
  parameter int WAIT_US     = 280_000,
  parameter int DEBOUNCE_US = 10_000
) (
  input  logic clk,
  input  logic rst,
  input  logic buttonN,
  output logic chargerEnN,
  output logic triggerOut,
  output logic fireOut,
  output logic busy,
  output logic cycleDone
);
  localparam int PRESCALE = CLK_HZ / 1_000_000;
  localparam int DEB_CYC  = DEBOUNCE_US * PRESCALE;

  logic       pressed;
  logic       expired;
  timerCtrl_t tctl;

  flp_button_filter #(
    .SYNC_STAGES(2),
    .STABLE_CYC (DEB_CYC)
  ) i_filter (
    .clk    (clk),
    .rst    (rst),
    .btnRawN(buttonN),
    .pressed(pressed)
  );

  flp_interval_timer #(
    .PRESCALE (PRESCALE),
    .CHARGE_US(CHARGE_US),
    .PULSE_US (PULSE_US),
    .GAP_US   (GAP_US),
    .WAIT_US  (WAIT_US)
  ) i_timer (
    .clk    (clk),
    .rst    (rst),
    .tctl   (tctl),
    .expired(expired)
  );

  flp_sequence_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pressed   (pressed),
    .expired   (expired),
    .tctl      (tctl),
    .chargerEnN(chargerEnN),
    .triggerOut(triggerOut),
    .fireOut   (fireOut),
    .busy      (busy),
    .cycleDone (cycleDone)
  );
endmodule

// File: rtl/flp_sequencer_checker.sv
module flp_sequencer_checker (
  input logic clk,
  input logic rst,
  input logic chargerEnN,
  input logic triggerOut,
  input logic fireOut,
  input logic busy,
  input logic cycleDone
);
  // R8: outputs mutually exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~chargerEnN, triggerOut, fireOut}));

  // R3: idle means all outputs inactive
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (chargerEnN && !triggerOut && !fireOut));

  // R4: charger turns off exactly when trigger starts
  a_r4_charge_handoff: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(chargerEnN)) |-> triggerOut);

  // R5: end of trigger is followed by a quiet gap, not fire
  a_r5_gap_after_trigger: assert property (@(posedge clk) disable iff (rst)
    $fell(triggerOut) |-> (!fireOut && chargerEnN));

  // R5: fire never starts straight out of the trigger
  a_r5_fire_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(fireOut) |-> $past(!triggerOut));

  // R11: completion strobe is one cycle and only while busy
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    cycleDone |=> !cycleDone);

  a_r11_done_busy: assert property (@(posedge clk) disable iff (rst)
    cycleDone |-> (busy && chargerEnN && !triggerOut && !fireOut));
endmodule

bind flp_sequencer flp_sequencer_checker i_chk (
  .clk       (clk),
  .rst       (rst),
  .chargerEnN(chargerEnN),
  .triggerOut(triggerOut),
  .fireOut   (fireOut),
  .busy      (busy),
  .cycleDone (cycleDone)
);

// File: tb/test_flp_sequencer.sv
`timescale 1ns/1ps
module test_flp_sequencer;
  localparam int PRESC   = 4;
  localparam int CHG_US  = 50;
  localparam int PUL_US  = 9;
  localparam int GAP_US  = 16;
  localparam int WT_US   = 70;
  localparam int DEB_US  = 10;
  localparam int DEB_CYC = DEB_US * PRESC;

  // phase table: expected cycles per phase (charge R4, trigger R7, gap R5, fire R7, rest R6)
  localparam int EXP_CYC [5] = '{CHG_US*PRESC, PUL_US*PRESC, GAP_US*PRESC, PUL_US*PRESC, WT_US*PRESC};

  logic clk = 1'b0;
  logic rst;
  logic buttonN;
  logic chargerEnN, triggerOut, fireOut, busy, cycleDone;

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  int overlapCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flp_sequencer #(
    .CLK_HZ     (PRESC * 1_000_000),
    .CHARGE_US  (CHG_US),
    .PULSE_US   (PUL_US),
    .GAP_US     (GAP_US),
    .WAIT_US    (WT_US),
    .DEBOUNCE_US(DEB_US)
  ) i_flp_sequencer (
    .clk       (clk),
    .rst       (rst),
    .buttonN   (buttonN),
    .chargerEnN(chargerEnN),
    .triggerOut(triggerOut),
    .fireOut   (fireOut),
    .busy      (busy),
    .cycleDone (cycleDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitors sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (cycleDone) doneCnt++;
      if ((int'(!chargerEnN) + int'(triggerOut) + int'(fireOut)) > 1) overlapCnt++;
    end
  end

  function automatic bit phaseActive(input int ph);
    case (ph)
      0: return !chargerEnN;
      1: return triggerOut;
      3: return fireOut;
      default: return busy && chargerEnN && !triggerOut && !fireOut;
    endcase
  endfunction

  task automatic measurePhase(input int ph, output int n);
    n = 0;
    while (phaseActive(ph) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    int lat;
    int w[5];
    rst = 1'b1;
    buttonN = 1'b1;
    repeat (4) @(negedge clk);
    // R2 R3: reset state
    check(chargerEnN == 1'b1, "R2 reset charger off", int'(chargerEnN), 1);
    check(!triggerOut && !fireOut, "R3 reset pulses low", int'(triggerOut) + int'(fireOut), 0);
    check(!busy && !cycleDone, "R3 reset busy low", int'(busy), 0);
    rst = 1'b0;

    // R1: released button keeps block idle
    repeat (300) @(negedge clk);
    check(!busy && chargerEnN, "R1 idle while released", int'(busy), 0);

    // R9: glitch shorter than debounce time starts nothing
    buttonN = 1'b0;
    repeat (DEB_CYC / 4) @(negedge clk);
    buttonN = 1'b1;
    repeat (200) @(negedge clk);
    check(!busy && chargerEnN, "R9 glitch ignored", int'(busy), 0);

    // R9: a held press starts charge only after debounce
    buttonN = 1'b0;
    lat = 0;
    while (chargerEnN && lat < 1000) begin
      lat++;
      @(negedge clk);
    end
    check(lat >= DEB_CYC && lat <= DEB_CYC + 8, "R9 debounce latency", lat, DEB_CYC + 3);
    check(busy, "R11 busy during charge", int'(busy), 1);

    // table walk: three cycles, released during the third (R10)
    for (int cyc = 0; cyc < 3; cyc++) begin
      for (int ph = 0; ph < 5; ph++) begin
        measurePhase(ph, n);
        w[ph] = n;
        check(n == EXP_CYC[ph], $sformatf("R4 R5 R6 R7 phase %0d cycle %0d width", ph, cyc), n, EXP_CYC[ph]);
        if (cyc == 2 && ph == 0) buttonN = 1'b1;
      end
      check(w[1] == w[3], "R7 trigger and fire equal", w[3], w[1]);
      if (cyc < 2)
        check(!chargerEnN && busy, "R6 restart while held", int'(chargerEnN), 0);
      else
        check(!busy && chargerEnN, "R6 R10 idle after completed cycle", int'(busy), 0);
    end
    check(doneCnt == 3, "R11 cycleDone count", doneCnt, 3);
    check(overlapCnt == 0, "R8 no overlap", overlapCnt, 0);

    // R3: reset during the trigger pulse forces outputs off
    buttonN = 1'b0;
    n = 0;
    while (!triggerOut && n < 2000) begin
      n++;
      @(negedge clk);
    end
    check(triggerOut, "R4 trigger reached", int'(triggerOut), 1);
    rst = 1'b1;
    @(negedge clk);
    check(!triggerOut && !fireOut && chargerEnN && !busy, "R3 reset mid-cycle",
          int'(triggerOut) + int'(busy), 0);
    buttonN = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    check(!busy, "R1 idle after reset with release", int'(busy), 0);
    finishRun();
  end
endmodule